// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Decoder and Bank Tracker

This block sits on the command side of a two-bank synchronous graphics DRAM. It samples chip select, the three row/column/write strobes, the special-function strobe, the bank select and a ten-bit address on every rising clock edge. It turns each sampled pattern into exactly one accepted command strobe or an error pulse, and it presents the bank, row, column and opcode fields that belong to that command.

It also keeps the state of both banks. For each bank it records whether the bank is idle or active, which row is open, and whether the activation asked for masked-write mode. It refuses commands that the bank state forbids, and it refuses a column access that comes too soon after its activation. A refused command changes no state. Refresh execution and the contents of the mode registers are left to other blocks.

The command code is {ras_n, cas_n, we_n, dsf}, and it only counts while cs_n is low. Bit positions of `cmd_oh` are: 0 activate, 1 precharge, 2 read, 3 write, 4 block write, 5 burst stop, 6 refresh, 7 mode set, 8 special mode set.

Top module: `sgram_cmd_tracker`

## Requirements
- R1: While cs_n is sampled high, no strobe and no error result, and the bank state does not change. The code 111x (no operation) behaves the same way with cs_n low.
- R2: Code 011x (activate) to an idle bank gives strobe bit 0 and makes bank bank_sel active. It also latches addr as that bank's open row (open_rows bits [10b+9:10b]) and latches dsf as that bank's masked_mode bit.
- R3: An activate to an active bank raises cmd_err and leaves the active flag, the row and the mode of every bank unchanged.
- R4: Code 0100 (precharge) is always accepted with strobe bit 1. With addr[9] high it idles both banks, otherwise only bank bank_sel. If the target bank is already idle, nothing changes.
- R5: Codes 1010 (read), 1000 (write) and 1001 (block write) to an active bank give strobe bit 2, 3 or 4 when at least RCD_CYC clocks separate them from that bank's activate. cmd_row then shows the open row and cmd_col shows addr[7:0]. If addr[9] is high, the bank becomes idle.
- R6: A read, write or block write to an idle bank, or one issued fewer than RCD_CYC clocks after its bank's activate, raises cmd_err and changes no state.
- R7: Code 0000 (mode set, strobe bit 7) and code 0010 (refresh, strobe bit 6) are accepted only while both banks are idle, and otherwise raise cmd_err. Code 0001 (special mode set, strobe bit 8) is always accepted. For both mode sets, cmd_opcode is {bank_sel, addr}.
- R8: Code 1100 (burst stop) is always accepted with strobe bit 5. The reserved codes 0101, 1011, 1101 and 0011 raise cmd_err and change nothing.
- R9: Outputs for a command sampled at clock edge N appear after edge N+1, together with the bank state that includes that command. At most one strobe is high at a time, and an error never comes with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low enables decoding |
| ras_n | input | 1 | Row strobe, command code bit 3 |
| cas_n | input | 1 | Column strobe, command code bit 2 |
| we_n | input | 1 | Write strobe, command code bit 1 |
| dsf | input | 1 | Special-function strobe, command code bit 0 |
| bank_sel | input | 1 | Target bank; opcode bit 10 on mode sets |
| addr | input | ROW_W | Row, column, auto-precharge/all-bank bit (top bit), opcode |
| cmd_oh | output | 9 | One-hot accepted command strobes |
| cmd_err | output | 1 | Pulse for a refused or reserved command |
| cmd_bank | output | 1 | Bank of the reported command |
| cmd_row | output | ROW_W | Row activated, or open row of a column access |
| cmd_col | output | COL_W | Column of a column access |
| cmd_ap | output | 1 | Address top bit: auto-precharge or all-bank |
| cmd_opcode | output | ROW_W+1 | Mode set opcode {bank_sel, addr} |
| bank_active | output | 2 | Active flag per bank |
| masked_mode | output | 2 | Masked-write mode latched per bank at activate |
| open_rows | output | 2*ROW_W | Open row per bank, bank 1 in the upper half |

## Verification
Directed sequences check the orderings that only the bank state can explain: a column access one clock after an activate against one two clocks after it, a second activate to the same bank, a mode set with a bank open against one after an all-bank precharge, and auto-precharge against a plain column access. Random commands, weighted toward activates and column accesses, then run both banks through long mixed histories. A bench model of the two banks predicts every strobe, error, open row and mode bit, so these runs expose wrong bank indexing, lost state after a refused command and faulty timer accounting. Deselected cycles whose strobe lines carry command patterns show that the decoder really ignores them.

// File: rtl/sgram_cmd_tracker.sv
module sgram_cmd_tracker #(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 8,
  parameter int RCD_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 dsf,
  input  logic                 bank_sel,
  input  logic [ROW_W-1:0]     addr,
  output logic [8:0]           cmd_oh,
  output logic                 cmd_err,
  output logic                 cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic                 cmd_ap,
  output logic [ROW_W:0]       cmd_opcode,
  output logic [1:0]           bank_active,
  output logic [1:0]           masked_mode,
  output logic [2*ROW_W-1:0]   open_rows
);
  localparam int CNT_W = (RCD_CYC < 2) ? 1 : $clog2(RCD_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RCD_CYC - 1);

  logic             q_cs_n, q_ras_n, q_cas_n, q_we_n, q_dsf, q_bs;
  logic [ROW_W-1:0] q_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cs_n  <= 1'b1;
      q_ras_n <= 1'b1;
      q_cas_n <= 1'b1;
      q_we_n  <= 1'b1;
      q_dsf   <= 1'b0;
      q_bs    <= 1'b0;
      q_addr  <= '0;
    end else begin
      q_cs_n  <= cs_n;
      q_ras_n <= ras_n;
      q_cas_n <= cas_n;
      q_we_n  <= we_n;
      q_dsf   <= dsf;
      q_bs    <= bank_sel;
      q_addr  <= addr;
    end
  end

  logic [3:0]       code;
  logic             sel, hi_bit;
  logic             act_b, ready_b, both_idle;
  logic             is_act, is_pre, is_rd, is_wr, is_bwr, is_bst, is_ref, is_mrs, is_smrs, is_nop;
  logic [8:0]       acc;
  logic             err;
  logic [ROW_W-1:0] row_q [2];
  logic [CNT_W-1:0] cnt_q [2];
  logic [1:0]       act_q, mm_q;

  assign sel       = !q_cs_n;
  assign code      = {q_ras_n, q_cas_n, q_we_n, q_dsf};
  assign hi_bit    = q_addr[ROW_W-1];
  assign act_b     = act_q[q_bs];
  assign ready_b   = (cnt_q[q_bs] == '0);
  assign both_idle = (act_q == 2'b00);

  assign is_act  = sel && (code[3:1] == 3'b011);
  assign is_pre  = sel && (code == 4'b0100);
  assign is_rd   = sel && (code == 4'b1010);
  assign is_wr   = sel && (code == 4'b1000);
  assign is_bwr  = sel && (code == 4'b1001);
  assign is_bst  = sel && (code == 4'b1100);
  assign is_ref  = sel && (code == 4'b0010);
  assign is_mrs  = sel && (code == 4'b0000);
  assign is_smrs = sel && (code == 4'b0001);
  assign is_nop  = sel && (code[3:1] == 3'b111);

  assign acc[0] = is_act && !act_b;
  assign acc[1] = is_pre;
  assign acc[2] = is_rd  && act_b && ready_b;
  assign acc[3] = is_wr  && act_b && ready_b;
  assign acc[4] = is_bwr && act_b && ready_b;
  assign acc[5] = is_bst;
  assign acc[6] = is_ref && both_idle;
  assign acc[7] = is_mrs && both_idle;
  assign acc[8] = is_smrs;

  assign err = sel && !is_nop && (acc == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 2'b00;
      mm_q  <= 2'b00;
      for (int i = 0; i < 2; i++) begin
        row_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (acc[0] && (q_bs == i[0])) cnt_q[i] <= CNT_LOAD;
        else if (cnt_q[i] != '0)      cnt_q[i] <= cnt_q[i] - 1'b1;
      end
      if (acc[0]) begin
        act_q[q_bs] <= 1'b1;
        row_q[q_bs] <= q_addr;
        mm_q[q_bs]  <= q_dsf;
      end
      if (acc[1]) begin
        if (hi_bit) act_q <= 2'b00;
        else        act_q[q_bs] <= 1'b0;
      end
      if ((acc[2] || acc[3] || acc[4]) && hi_bit) act_q[q_bs] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_oh     <= '0;
      cmd_err    <= 1'b0;
      cmd_bank   <= 1'b0;
      cmd_row    <= '0;
      cmd_col    <= '0;
      cmd_ap     <= 1'b0;
      cmd_opcode <= '0;
    end else begin
      cmd_oh     <= acc;
      cmd_err    <= err;
      cmd_bank   <= q_bs;
      cmd_row    <= acc[0] ? q_addr : row_q[q_bs];
      cmd_col    <= q_addr[COL_W-1:0];
      cmd_ap     <= hi_bit;
      cmd_opcode <= {q_bs, q_addr};
    end
  end

  assign bank_active = act_q;
  assign masked_mode = mm_q;
  assign open_rows   = {row_q[1], row_q[0]};
endmodule

// File: rtl/sgram_cmd_tracker_chk.sv
module sgram_cmd_tracker_chk #(
  parameter int ROW_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic [8:0]         cmd_oh,
  input logic               cmd_err,
  input logic               cmd_bank,
  input logic               cmd_ap,
  input logic [1:0]         bank_active,
  input logic [2*ROW_W-1:0] open_rows
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_oh));                                               // R9
  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (cmd_oh == '0));                                     // R9
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> (cmd_oh == '0 && !cmd_err));                  // R1
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[0] |-> bank_active[cmd_bank]);                            // R2
  AST_ROWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oh[0] |-> $stable(open_rows));                              // R3
  AST_PREALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oh[1] && cmd_ap) |-> (bank_active == 2'b00));               // R4
  AST_MODESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oh[7] || cmd_oh[6]) |-> (bank_active == 2'b00));            // R7
endmodule

bind sgram_cmd_tracker sgram_cmd_tracker_chk #(.ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_oh(cmd_oh), .cmd_err(cmd_err),
  .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .bank_active(bank_active), .open_rows(open_rows)
);

// File: tb/sgram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sgram_cmd_tracker_tb_top;
  localparam int ROW_W = 10;
  localparam int COL_W = 8;
  localparam int RCD   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0, bank_sel = 1'b0;
  logic [ROW_W-1:0]   addr = '0;
  logic [8:0]         cmd_oh;
  logic               cmd_err, cmd_bank, cmd_ap;
  logic [ROW_W-1:0]   cmd_row;
  logic [COL_W-1:0]   cmd_col;
  logic [ROW_W:0]     cmd_opcode;
  logic [1:0]         bank_active, masked_mode;
  logic [2*ROW_W-1:0] open_rows;

  sgram_cmd_tracker #(.ROW_W(ROW_W), .COL_W(COL_W), .RCD_CYC(RCD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dsf(dsf), .bank_sel(bank_sel), .addr(addr), .cmd_oh(cmd_oh), .cmd_err(cmd_err),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .cmd_opcode(cmd_opcode), .bank_active(bank_active), .masked_mode(masked_mode),
    .open_rows(open_rows)
  );

  int n_chk = 0, n_fail = 0;
  int k = 0, k1 = -1, k2 = -2;
  logic [15:0] d1, d2;
  bit          m_act [2];
  bit          m_mm [2];
  logic [ROW_W-1:0] m_row [2];
  int          m_actk [2];
  bit          finished = 1'b0;

  function automatic logic [15:0] mk(bit cs, bit ra, bit ca, bit we, bit ds, bit bs, logic [ROW_W-1:0] a);
    return {cs, ra, ca, we, ds, bs, a};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model(input logic [15:0] c, input int kk);
    logic [3:0] code;
    bit b;
    logic [ROW_W-1:0] a, exp_row;
    logic [8:0] oh;
    bit er;
    string tag;
    code = c[14:11]; b = c[10]; a = c[9:0];
    oh = '0; er = 1'b0; tag = "R1"; exp_row = m_row[b];
    if (!c[15]) begin
      casez (code)
        4'b011?: if (!m_act[b]) begin
                   tag = "R2"; oh[0] = 1'b1; m_act[b] = 1'b1; m_row[b] = a;
                   m_mm[b] = code[0]; m_actk[b] = kk;
                 end else begin tag = "R3"; er = 1'b1; end
        4'b0100: begin
                   tag = "R4"; oh[1] = 1'b1;
                   if (a[ROW_W-1]) begin m_act[0] = 1'b0; m_act[1] = 1'b0; end
                   else m_act[b] = 1'b0;
                 end
        4'b1010, 4'b1000, 4'b1001:
                 if (m_act[b] && (kk - m_actk[b] >= RCD)) begin
                   tag = "R5";
                   oh[(code == 4'b1010) ? 2 : (code == 4'b1000) ? 3 : 4] = 1'b1;
                   if (a[ROW_W-1]) m_act[b] = 1'b0;
                 end else begin tag = "R6"; er = 1'b1; end
        4'b1100: begin tag = "R8"; oh[5] = 1'b1; end
        4'b0010: begin tag = "R7"; if (!m_act[0] && !m_act[1]) oh[6] = 1'b1; else er = 1'b1; end
        4'b0000: begin tag = "R7"; if (!m_act[0] && !m_act[1]) oh[7] = 1'b1; else er = 1'b1; end
        4'b0001: begin tag = "R7"; oh[8] = 1'b1; end
        4'b111?: tag = "R1";
        default: begin tag = "R8"; er = 1'b1; end
      endcase
    end
    chk(tag, "strobes", 32'(cmd_oh), 32'(oh));
    chk(tag, "error", 32'(cmd_err), 32'(er));
    chk(tag, "bank_active", 32'(bank_active), {30'b0, m_act[1], m_act[0]});
    chk(tag, "masked_mode", 32'(masked_mode), {30'b0, m_mm[1], m_mm[0]});
    chk(tag, "open_rows", 32'(open_rows), 32'({m_row[1], m_row[0]}));
    if (oh[0]) chk("R2", "act row", 32'(cmd_row), 32'(a));
    if (oh[0] || oh[1] || oh[2] || oh[3] || oh[4]) chk(tag, "bank", 32'(cmd_bank), 32'(b));
    if (oh[2] || oh[3] || oh[4]) begin
      chk("R5", "row", 32'(cmd_row), 32'(exp_row));
      chk("R5", "col", 32'(cmd_col), 32'(a[COL_W-1:0]));
    end
    if (oh[1]) chk("R4", "all-bank bit", 32'(cmd_ap), 32'(a[ROW_W-1]));
    if (oh[7] || oh[8]) chk("R7", "opcode", 32'(cmd_opcode), 32'({b, a}));
  endtask

  task automatic step(input logic [15:0] c);
    @(negedge clk);
    model(d2, k2);
    d2 = d1; k2 = k1;
    d1 = c;  k1 = k;
    k++;
    {cs_n, ras_n, cas_n, we_n, dsf, bank_sel, addr} = c;
  endtask

  function automatic logic [15:0] rand_cmd();
    int r;
    bit bs;
    logic [ROW_W-1:0] a;
    logic [3:0] rsv [4];
    rsv[0] = 4'b0101; rsv[1] = 4'b1011; rsv[2] = 4'b1101; rsv[3] = 4'b0011;
    bs = 1'($urandom);
    a = ROW_W'($urandom);
    a[ROW_W-1] = (($urandom % 4) == 0);
    r = $urandom % 100;
    if (r < 10) return {1'b1, 4'($urandom), bs, a};
    r = $urandom % 14;
    case (r)
      0, 1, 2: return mk(0, 0, 1, 1, 1'($urandom), bs, a);
      3:       return mk(0, 0, 1, 0, 0, bs, a);
      4, 5:    return mk(0, 1, 0, 1, 0, bs, a);
      6, 7:    return mk(0, 1, 0, 0, 0, bs, a);
      8:       return mk(0, 1, 0, 0, 1, bs, a);
      9:       return mk(0, 1, 1, 0, 0, bs, a);
      10:      return mk(0, 0, 0, 1, 0, bs, a);
      11:      return mk(0, 0, 0, 0, 1'($urandom), bs, a);
      12:      return mk(0, 1, 1, 1, 1'($urandom), bs, a);
      default: return {1'b0, rsv[$urandom % 4], bs, a};
    endcase
  endfunction

  localparam logic [15:0] NOPC = {5'b11110, 1'b0, 10'd0};

  initial begin
    int seed;
    seed = $urandom(32'h5eed_2024);
    d1 = NOPC; d2 = NOPC;
    for (int i = 0; i < 2; i++) begin
      m_act[i] = 1'b0; m_mm[i] = 1'b0; m_row[i] = '0; m_actk[i] = -100;
    end
    repeat (3) @(negedge clk);
    chk("R9", "reset strobes", 32'(cmd_oh), 0);
    chk("R9", "reset error", 32'(cmd_err), 0);
    chk("R9", "reset banks", 32'(bank_active), 0);
    chk("R9", "reset rows", 32'(open_rows), 0);
    rst_n = 1'b1;
    // directed corners
    step(mk(1, 0, 1, 1, 0, 0, 10'h0AA));   // R1 deselected activate pattern
    step(mk(0, 0, 1, 1, 1, 0, 10'h155));   // R2 activate bank0, masked mode
    step(mk(0, 1, 0, 1, 0, 0, 10'h012));   // R6 read too early
    step(mk(0, 1, 0, 1, 0, 0, 10'h034));   // R5 read at RCD
    step(mk(0, 0, 1, 1, 0, 0, 10'h0FF));   // R3 activate active bank
    step(mk(0, 0, 0, 0, 0, 0, 10'h033));   // R7 mode set refused
    step(mk(0, 0, 0, 0, 1, 1, 10'h2C3));   // R7 special mode set accepted
    step(mk(0, 1, 0, 0, 1, 1, 10'h001));   // R6 block write to idle bank
    step(mk(0, 0, 1, 1, 0, 1, 10'h3E1));   // R2 activate bank1
    step(mk(0, 1, 1, 1, 0, 0, 10'h000));   // R1 nop
    step(mk(0, 1, 0, 0, 0, 1, 10'h277));   // R5 write with auto-precharge
    step(mk(0, 0, 1, 0, 0, 1, 10'h000));   // R4 precharge idle bank
    step(mk(0, 1, 1, 0, 1, 0, 10'h000));   // R8 reserved code
    step(mk(0, 1, 1, 0, 0, 0, 10'h000));   // R8 burst stop
    step(mk(0, 0, 1, 0, 0, 1, 10'h200));   // R4 precharge all
    step(mk(0, 0, 0, 0, 0, 1, 10'h1A5));   // R7 mode set accepted
    step(mk(0, 0, 0, 1, 0, 0, 10'h000));   // R7 refresh accepted
    step(mk(0, 0, 0, 1, 1, 0, 10'h000));   // R8 reserved refresh code
    for (int i = 0; i < 4000; i++) step(rand_cmd());
    step(NOPC);
    step(NOPC);
    step(NOPC);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule